// File: doc/BRIEF.md
# Programmable-Size PCI Base Address Decoder

This block holds the base address registers of a PCI-style target and decodes bus addresses against them. There are six windows. One is an I/O window for device registers. One is a memory window for device registers. Four more are memory windows whose size comes from a 4-bit code that software writes into a device control word. Software reaches the command bits, the control word and the six bases through a simple configuration port with a write strobe and a combinational read path.

Each base holds only the bits above its window size. The bits below that size read as zero and ignore writes, and a disabled window reads as all zeros. When the size or enable changes, the stored base is re-masked, so any bits that the new size does not cover are lost.

Address lookups arrive on a valid/ready request channel. Each accepted request produces one registered response that carries a one-hot hit vector and the offset of the address inside the matching window. A response stays on the output unchanged while `rsp_rdy_i` is low. A new request is accepted only when the output stage is empty or is being drained in the same cycle. A stalled consumer therefore stops the request side, and no lookup is lost.

Top module: `bardec_top`

## Requirements
- R1: The control word (config index 1) holds one 4-bit code per sized memory window. Window k uses bits 4k+3..4k, for k = 0..3. Code 0 disables that window: it never hits and its base (index 4+k) reads zero.
- R2: Codes 1 to 12 give window sizes of 2^(32-code) bytes, from 2 GB down to 1 MB.
- R3: Codes 13, 14 and 15 give 64 KB, 32 KB and 16 KB windows. For those codes only, `win_en_o[k]` is high.
- R4: For a window of 2^n bytes, base bits below n read back as zero and ignore writes. Bits n and above hold the written value.
- R5: A write to the control word takes effect on the following cycle. From then on, each base is masked to its new size, and bits cleared by a smaller size stay cleared if the size grows again.
- R6: The I/O register window (index 2, 256 bytes) is enabled by control bit 16. While that bit is clear, the window reads zero and writes are dropped. It hits only on I/O requests (`req_io_i` = 1) when both control bit 16 and command bit 0 are set.
- R7: The memory register window (index 3, 4 KB) is enabled by control bit 17. While that bit is clear, it reads zero. It hits only on memory requests when both bit 17 and command bit 1 are set.
- R8: A sized window hits on a memory request only when command bit 1 is set, its code is nonzero, and the address bits from n upward equal the stored base.
- R9: The hit vector has bit 0 for the I/O window, bit 1 for the register memory window, and bit 2+k for sized window k. It has at most one bit set, and the lowest matching bit wins. The offset is the address bits below n of the winner. A miss gives an all-zero vector and a zero offset.
- R10: `req_rdy_o` equals `!rsp_vld_o || rsp_rdy_i`. While `rsp_vld_o` is high and `rsp_rdy_i` is low, the response is held unchanged.
- R11: After reset, the command bits, the control word and all bases are zero, every window is disabled, and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 3 | Register index: 0 command, 1 control, 2 I/O window, 3 register memory window, 4-7 sized windows |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_idx_i` (combinational) |
| req_vld_i | input | 1 | Lookup request valid |
| req_rdy_o | output | 1 | Lookup request ready |
| req_addr_i | input | 32 | Bus address to decode |
| req_io_i | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| rsp_vld_o | output | 1 | Response valid |
| rsp_rdy_i | input | 1 | Response ready |
| rsp_hit_o | output | 6 | One-hot hit vector |
| rsp_off_o | output | 32 | Offset inside the matching window |
| win_en_o | output | 4 | Internal-windowing enable per sized window |

## Verification
The bench targets several corner cases.

- It sweeps every code on one window and probes the first byte, the last byte and the byte one past the end. An off-by-one in the size table shows up as a hit one window too far or a miss on the last byte. At 2 GB, the address one past the end wraps to zero.
- It makes windows overlap, to show that a design with no priority raises two hit bits at once.
- It shrinks a window and then grows it back. A design that masks only at read time would bring back the lost bits.
- It writes the I/O base while that window is disabled, then enables it. A design that keeps such writes would read them back.
- It stalls the consumer with an irregular ready pattern, so a response that is overwritten or dropped shows up as a wrong value.

// File: rtl/bardec_pkg.sv
package bardec_pkg;
  localparam int ADDR_W  = 32;
  localparam int CODE_W  = 4;
  localparam int N_SIZED = 4;
  localparam int N_WIN   = N_SIZED + 2;
  localparam int CTRL_W  = CODE_W * N_SIZED + 2;
  localparam int IO_EN_BIT  = CODE_W * N_SIZED;
  localparam int REG_EN_BIT = CODE_W * N_SIZED + 1;
  localparam int N_CFG   = N_WIN + 2;
  localparam int IDX_W   = $clog2(N_CFG);
  localparam int LOG_OFF = ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;

  // Window size exponent for a size code; ADDR_W marks "disabled".
  function automatic int unsigned code_log2(input logic [CODE_W-1:0] c);
    int unsigned lg;
    if (c == '0)
      lg = LOG_OFF;
    else if (c <= 4'd12)
      lg = 32 - int'(c);
    else
      lg = 16 - (int'(c) - 13);
    return lg;
  endfunction

  function automatic addr_t log2_mask(input int unsigned lg);
    addr_t m;
    if (lg >= ADDR_W)
      m = '0;
    else
      m = {ADDR_W{1'b1}} << lg;
    return m;
  endfunction
endpackage

// File: rtl/bardec_size_map.sv
module bardec_size_map
  import bardec_pkg::*;
#(
  parameter int NS = N_SIZED
) (
  input  logic [CODE_W*NS-1:0] codes_i,
  output addr_t                mask_o [NS],
  output logic [NS-1:0]        live_o,
  output logic [NS-1:0]        win_o
);
  localparam logic [CODE_W-1:0] FIRST_SMALL = CODE_W'(13);

  for (genvar k = 0; k < NS; k++) begin : g_code
    logic [CODE_W-1:0] c;
    assign c         = codes_i[k*CODE_W +: CODE_W];
    assign mask_o[k] = log2_mask(code_log2(c));
    assign live_o[k] = (c != '0);
    assign win_o[k]  = (c >= FIRST_SMALL);
  end
endmodule

// File: rtl/bardec_bar_slot.sv
module bardec_bar_slot
  import bardec_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  addr_t mask_i,
  input  logic  wr_i,
  input  addr_t wdata_i,
  input  logic  act_i,
  input  addr_t addr_i,
  output addr_t rdata_o,
  output logic  hit_o,
  output addr_t off_o
);
  addr_t base_q;

  // Re-mask every cycle so bits dropped by a smaller size stay dropped.
  always_ff @(posedge clk) begin
    if (rst)
      base_q <= '0;
    else if (wr_i)
      base_q <= wdata_i & mask_i;
    else
      base_q <= base_q & mask_i;
  end

  assign rdata_o = base_q & mask_i;
  assign hit_o   = act_i && ((addr_i & mask_i) == rdata_o);
  assign off_o   = addr_i & ~mask_i;
endmodule

// File: rtl/bardec_hit_sel.sv
module bardec_hit_sel
  import bardec_pkg::*;
#(
  parameter int NW = N_WIN
) (
  input  logic [NW-1:0] hits_i,
  input  addr_t         offs_i [NW],
  output logic [NW-1:0] onehot_o,
  output addr_t         off_o
);
  always_comb begin
    onehot_o = '0;
    off_o    = '0;
    for (int k = NW - 1; k >= 0; k--) begin
      if (hits_i[k]) begin
        onehot_o    = '0;
        onehot_o[k] = 1'b1;
        off_o       = offs_i[k];
      end
    end
  end
endmodule

// File: rtl/bardec_top.sv
module bardec_top
  import bardec_pkg::*;
#(
  parameter int IO_LOG2  = 8,
  parameter int REG_LOG2 = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic [ADDR_W-1:0]    cfg_wdata_i,
  output logic [ADDR_W-1:0]    cfg_rdata_o,
  input  logic                 req_vld_i,
  output logic                 req_rdy_o,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic                 req_io_i,
  output logic                 rsp_vld_o,
  input  logic                 rsp_rdy_i,
  output logic [N_WIN-1:0]     rsp_hit_o,
  output logic [ADDR_W-1:0]    rsp_off_o,
  output logic [N_SIZED-1:0]   win_en_o
);
  localparam int          IDX_CMD  = 0;
  localparam int          IDX_CTRL = 1;
  localparam int          IDX_WIN0 = 2;
  localparam int          SLOT_IO  = 0;
  localparam int          SLOT_REG = 1;
  localparam int          SLOT_SZ0 = 2;

  logic [1:0]        cmd_q;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      ctrl_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_idx_i == IDX_W'(IDX_CMD))  cmd_q  <= cfg_wdata_i[1:0];
      if (cfg_idx_i == IDX_W'(IDX_CTRL)) ctrl_q <= cfg_wdata_i[CTRL_W-1:0];
    end
  end

  addr_t              sz_mask [N_SIZED];
  logic [N_SIZED-1:0] sz_live;

  bardec_size_map #(.NS(N_SIZED)) u_map (
    .codes_i (ctrl_q[CODE_W*N_SIZED-1:0]),
    .mask_o  (sz_mask),
    .live_o  (sz_live),
    .win_o   (win_en_o)
  );

  addr_t            slot_mask [N_WIN];
  logic [N_WIN-1:0] slot_act;
  addr_t            slot_rd   [N_WIN];
  addr_t            slot_off  [N_WIN];
  logic [N_WIN-1:0] slot_hit;

  assign slot_mask[SLOT_IO]  = ctrl_q[IO_EN_BIT]  ? log2_mask(IO_LOG2)  : '0;
  assign slot_mask[SLOT_REG] = ctrl_q[REG_EN_BIT] ? log2_mask(REG_LOG2) : '0;
  assign slot_act[SLOT_IO]   = req_io_i && cmd_q[0] && ctrl_q[IO_EN_BIT];
  assign slot_act[SLOT_REG]  = !req_io_i && cmd_q[1] && ctrl_q[REG_EN_BIT];

  for (genvar k = 0; k < N_SIZED; k++) begin : g_sz
    assign slot_mask[SLOT_SZ0+k] = sz_mask[k];
    assign slot_act[SLOT_SZ0+k]  = !req_io_i && cmd_q[1] && sz_live[k];
  end

  for (genvar w = 0; w < N_WIN; w++) begin : g_slot
    bardec_bar_slot u_slot (
      .clk     (clk),
      .rst     (rst),
      .mask_i  (slot_mask[w]),
      .wr_i    (cfg_we_i && (cfg_idx_i == IDX_W'(IDX_WIN0 + w))),
      .wdata_i (cfg_wdata_i),
      .act_i   (slot_act[w]),
      .addr_i  (req_addr_i),
      .rdata_o (slot_rd[w]),
      .hit_o   (slot_hit[w]),
      .off_o   (slot_off[w])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_idx_i == IDX_W'(IDX_CMD))
      cfg_rdata_o = ADDR_W'(cmd_q);
    else if (cfg_idx_i == IDX_W'(IDX_CTRL))
      cfg_rdata_o = ADDR_W'(ctrl_q);
    else
      for (int w = 0; w < N_WIN; w++)
        if (cfg_idx_i == IDX_W'(IDX_WIN0 + w))
          cfg_rdata_o = slot_rd[w];
  end

  logic [N_WIN-1:0] sel_hit;
  addr_t            sel_off;

  bardec_hit_sel #(.NW(N_WIN)) u_sel (
    .hits_i   (slot_hit),
    .offs_i   (slot_off),
    .onehot_o (sel_hit),
    .off_o    (sel_off)
  );

  logic take;
  assign req_rdy_o = !rsp_vld_o || rsp_rdy_i;
  assign take      = req_vld_i && req_rdy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld_o <= 1'b0;
      rsp_hit_o <= '0;
      rsp_off_o <= '0;
    end else if (take) begin
      rsp_vld_o <= 1'b1;
      rsp_hit_o <= sel_hit;
      rsp_off_o <= sel_off;
    end else if (rsp_rdy_i) begin
      rsp_vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bardec_chk.sv
module bardec_chk
  import bardec_pkg::*;
#(
  parameter int IO_LOG2 = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  cfg_idx_i,
  input logic [ADDR_W-1:0] cfg_rdata_o,
  input logic              req_vld_i,
  input logic              req_rdy_o,
  input logic              rsp_vld_o,
  input logic              rsp_rdy_i,
  input logic [N_WIN-1:0]  rsp_hit_o,
  input logic [ADDR_W-1:0] rsp_off_o,
  input logic [CTRL_W-1:0] ctrl_q
);
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    rsp_vld_o |-> $onehot0(rsp_hit_o)); // R9

  AST_MISS_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld_o && rsp_hit_o == '0) |-> rsp_off_o == '0); // R9

  AST_IO_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld_o && rsp_hit_o[0]) |-> rsp_off_o[ADDR_W-1:IO_LOG2] == '0); // R9

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld_o && !rsp_rdy_i) |=> (rsp_vld_o && $stable(rsp_hit_o) && $stable(rsp_off_o))); // R10

  AST_IO_DIS_READ: assert property (@(posedge clk) disable iff (rst)
    (cfg_idx_i == IDX_W'(2) && !ctrl_q[IO_EN_BIT]) |-> cfg_rdata_o == '0); // R6

  for (genvar k = 0; k < N_SIZED; k++) begin : g_off
    AST_CODE0_NO_HIT: assert property (@(posedge clk) disable iff (rst)
      (req_vld_i && req_rdy_o && ctrl_q[k*CODE_W +: CODE_W] == '0) |=> !rsp_hit_o[2+k]); // R1
  end
endmodule

bind bardec_top bardec_chk #(.IO_LOG2(IO_LOG2)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_idx_i   (cfg_idx_i),
  .cfg_rdata_o (cfg_rdata_o),
  .req_vld_i   (req_vld_i),
  .req_rdy_o   (req_rdy_o),
  .rsp_vld_o   (rsp_vld_o),
  .rsp_rdy_i   (rsp_rdy_i),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_off_o   (rsp_off_o),
  .ctrl_q      (ctrl_q)
);

// File: tb/tb_bardec_top.sv
module tb_bardec_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        req_vld_i = 1'b0;
  logic        req_rdy_o;
  logic [31:0] req_addr_i = '0;
  logic        req_io_i = 1'b0;
  logic        rsp_vld_o;
  logic        rsp_rdy_i = 1'b1;
  logic [5:0]  rsp_hit_o;
  logic [31:0] rsp_off_o;
  logic [3:0]  win_en_o;

  bardec_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  // Reference state
  logic [31:0] m_base [6];
  logic [1:0]  m_cmd = '0;
  logic [17:0] m_ctrl = '0;
  logic        m_rv = 1'b0;
  logic [5:0]  m_hit = '0;
  logic [31:0] m_off = '0;

  function automatic int lg_code(input logic [3:0] c);
    if (c == 0) return 32;          // R1 disabled
    if (c <= 12) return 32 - c;     // R2
    return 29 - c;                  // R3: 13->16, 14->15, 15->14
  endfunction

  function automatic logic [31:0] msk(input int lg);
    logic [31:0] m = '0;
    for (int b = 0; b < 32; b++) m[b] = (b >= lg);
    return m;
  endfunction

  function automatic logic [31:0] win_mask(input int w, input logic [17:0] ct);
    if (w == 0) return ct[16] ? msk(8) : 32'h0;   // R6
    if (w == 1) return ct[17] ? msk(12) : 32'h0;  // R7
    return msk(lg_code(ct[(w-2)*4 +: 4]));
  endfunction

  function automatic logic win_live(input int w, input logic io, input logic [1:0] cm,
                                    input logic [17:0] ct);
    if (w == 0) return io && cm[0] && ct[16];
    if (w == 1) return !io && cm[1] && ct[17];
    return !io && cm[1] && (ct[(w-2)*4 +: 4] != 0); // R8
  endfunction

  function automatic logic [31:0] exp_rd(input int idx);
    if (idx == 0) return {30'b0, m_cmd};
    if (idx == 1) return {14'b0, m_ctrl};
    return m_base[idx-2] & win_mask(idx-2, m_ctrl);
  endfunction

  task automatic cyc(input logic we, input int idx, input logic [31:0] wd,
                     input logic rv, input logic [31:0] ra, input logic rio,
                     input logic rr, input string tag);
    logic [31:0] e_rd;
    logic [3:0]  e_win;
    logic [5:0]  dh;
    logic [31:0] doff;
    logic [31:0] nb [6];
    @(negedge clk);
    cfg_we_i = we; cfg_idx_i = 3'(idx); cfg_wdata_i = wd;
    req_vld_i = rv; req_addr_i = ra; req_io_i = rio; rsp_rdy_i = rr;
    #1;
    e_rd = exp_rd(idx);
    for (int k = 0; k < 4; k++) e_win[k] = (m_ctrl[k*4 +: 4] >= 13);
    n_vec++;
    if (cfg_rdata_o !== e_rd || win_en_o !== e_win || rsp_vld_o !== m_rv ||
        req_rdy_o !== (!m_rv || rr) ||
        (m_rv && (rsp_hit_o !== m_hit || rsp_off_o !== m_off))) begin
      n_bad++;
      $display("FAIL %s: rd=%h/%h win=%b/%b vld=%b/%b rdy=%b hit=%b/%b off=%h/%h",
               tag, cfg_rdata_o, e_rd, win_en_o, e_win, rsp_vld_o, m_rv, req_rdy_o,
               rsp_hit_o, m_hit, rsp_off_o, m_off);
    end
    // decode with pre-edge state
    dh = '0; doff = '0;
    for (int w = 5; w >= 0; w--) begin
      logic [31:0] mm;
      mm = win_mask(w, m_ctrl);
      if (win_live(w, rio, m_cmd, m_ctrl) &&
          ((ra & mm) == (m_base[w] & mm))) begin
        dh = 6'(1) << w; doff = ra & ~mm;
      end
    end
    @(posedge clk);
    for (int w = 0; w < 6; w++)
      nb[w] = ((we && idx == w + 2) ? wd : m_base[w]) & win_mask(w, m_ctrl);
    if (rv && (!m_rv || rr)) begin
      m_rv = 1'b1; m_hit = dh; m_off = doff;
    end else if (rr) m_rv = 1'b0;
    for (int w = 0; w < 6; w++) m_base[w] = nb[w];
    if (we && idx == 0) m_cmd = wd[1:0];
    if (we && idx == 1) m_ctrl = wd[17:0];
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input string tag);
    cyc(1'b1, idx, d, 1'b0, 32'h0, 1'b0, 1'b1, tag);
  endtask
  task automatic rd(input int idx, input string tag);
    cyc(1'b0, idx, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, tag);
  endtask
  task automatic rq(input logic [31:0] a, input logic io, input string tag);
    cyc(1'b0, 2, 32'h0, 1'b1, a, io, 1'b1, tag);
    rd(2, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not end (act=hung exp=done)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 6; w++) m_base[w] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11: reset state, no hit with nothing enabled
    for (int i = 0; i < 8; i++) rd(i, "R11");
    rq(32'h0000_0000, 1'b0, "R11");
    rq(32'h0000_0000, 1'b1, "R11");

    wr(0, 32'h3, "R8");

    // R2 R3 R4: sweep codes on sized window 0, probe edges
    for (int c = 1; c < 16; c++) begin
      logic [31:0] sz;
      wr(1, 32'(c), "R2");
      wr(4, 32'hFFFF_FFFF, "R4");
      rd(4, "R4");
      wr(4, 32'hA5A5_A5A5, "R4");
      rd(4, "R4");
      sz = 32'h1 << lg_code(4'(c));
      rq(32'hA5A5_A5A5 & ~(sz - 1), 1'b0, c > 12 ? "R3" : "R2");
      rq((32'hA5A5_A5A5 & ~(sz - 1)) + sz - 1, 1'b0, c > 12 ? "R3" : "R2");
      rq((32'hA5A5_A5A5 & ~(sz - 1)) + sz, 1'b0, "R8");
    end

    // R1: nibble positions, code 0 disables
    wr(1, 32'h0000_D3F0, "R1");
    for (int k = 0; k < 4; k++) wr(4 + k, 32'hFFFF_FFFF, "R1");
    for (int k = 0; k < 4; k++) rd(4 + k, "R1");
    rq(32'hFFFF_FFFF, 1'b0, "R1");
    rq(32'hE000_0000, 1'b0, "R1");
    wr(1, 32'h0000_0000, "R1");
    rd(4, "R1");
    rq(32'hFFFF_C000, 1'b0, "R1");

    // R5: shrink-grow loses bits, same-cycle change
    wr(1, 32'h0000_000F, "R5");
    wr(4, 32'hFFFF_FFFF, "R5");
    wr(1, 32'h0000_0001, "R5");
    rd(4, "R5");
    wr(1, 32'h0000_000F, "R5");
    rd(4, "R5");
    wr(1, 32'h0000_0001, "R5");
    wr(1, 32'h0000_000F, "R5");
    rd(4, "R5");

    // R6: I/O window enable, dropped write, command gate
    wr(2, 32'h1234_5678, "R6");
    rd(2, "R6");
    rq(32'h1234_56AB, 1'b1, "R6");
    wr(1, 32'h0001_0000, "R6");
    rd(2, "R6");
    wr(2, 32'h1234_5678, "R6");
    rd(2, "R6");
    rq(32'h1234_56AB, 1'b1, "R6");
    rq(32'h1234_56AB, 1'b0, "R6");
    rq(32'h1234_57AB, 1'b1, "R6");
    wr(0, 32'h2, "R6");
    rq(32'h1234_56AB, 1'b1, "R6");

    // R7: register memory window
    wr(0, 32'h3, "R7");
    wr(3, 32'h0000_1FFF, "R7");
    rd(3, "R7");
    rq(32'h0000_1004, 1'b0, "R7");
    wr(1, 32'h0002_0000, "R7");
    wr(3, 32'h0000_1FFF, "R7");
    rd(3, "R7");
    rq(32'h0000_1004, 1'b0, "R7");
    wr(0, 32'h1, "R7");
    rq(32'h0000_1004, 1'b0, "R7");
    wr(0, 32'h3, "R8");

    // R9: overlap priority
    wr(1, 32'h0002_0001, "R9");
    wr(4, 32'h0000_0000, "R9");
    rq(32'h0000_1004, 1'b0, "R9");
    rq(32'h0000_2004, 1'b0, "R9");
    wr(1, 32'h0002_0DCC, "R9");
    wr(5, 32'h0000_0000, "R9");
    wr(6, 32'h0000_0000, "R9");
    wr(7, 32'h0000_0000, "R9");
    rq(32'h0000_0123, 1'b0, "R9");
    rq(32'h0001_0123, 1'b0, "R9");

    // R10: back-pressure with irregular ready
    for (int i = 0; i < 40; i++)
      cyc(1'b0, 1, 32'h0, (i % 3) != 2, 32'h0000_0040 * i + 32'(i),
          1'b0, ((i * 7) % 5) < 2, "R10");
    for (int i = 0; i < 4; i++)
      cyc(1'b0, 1, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule